// File: doc/BRIEF.md
# PWM Register Synchronisation Trigger Controller

This block decides the moment at which a PWM timer's buffered settings become live. Software writes new values into a buffer, covering the modulus, the counter start value, the per-channel compare values, the output mask, the pair inversion controls and the software output overrides. Those values are copied into the active set only when a synchronisation happens. A synchronisation can be requested in two ways: by a rising edge on one of three asynchronous hardware trigger inputs, or by software writing 1 to a software-sync bit.

Each hardware trigger has an enable bit, and so does the software request. These bits clear themselves according to the selected mode. A request either waits for the next loading point or completes immediately. An immediate completion also pulses a counter-reinitialise strobe, so the timer counter restarts from its start value. The enable bits and the software-sync bit are exported live, so a bus wrapper can read them back.

Top module: `pwm_sync_ctrl`

## Requirements
- R1: The active outputs (modulus, start value, channel values, mask, inversion and software override) change only on an edge after which `load_o` is 1. In that same cycle they show the buffered values that were present before the edge.
- R2: A hardware trigger input is passed through two synchroniser flops and a rising-edge detector. A 0-to-1 transition on `trig_i[k]` while `trg_en_o[k]` is 1 requests a synchronisation and is acted on at the third clock edge after the transition.
- R3: When the effective hold mode is off, a hardware trigger event clears only its own enable bit. Other set enable bits are unchanged.
- R4: If a trigger event occurs in the same cycle as a bus write of 1 to that trigger's enable bit, the enable bit stays 1 and the synchronisation is still requested.
- R5: Hold mode applies only when both `hw_trig_hold` and `enh_sync` are 1. In hold mode, trigger events never clear enable bits. With `enh_sync` = 0, the block behaves as with hold mode off.
- R6: A write of 1 to the software-sync bit is a software trigger. A write of 0 clears the bit and withdraws the pending software request.
- R7: The loading point is a cycle with `ld_pt_en` = 1 and `cnt_i` equal to `act_mod_o`. If a hardware or software request is pending at a loading point, `load_o` is 1 in the following cycle, the software-sync bit reads 0 in that cycle, and the enable bits read back unchanged.
- R8: A software trigger completes immediately when `enh_sync` = 1 and `sw_cnt_rst` = 1, or when `enh_sync` = 0, `pwmsync_sel` = 0 and `reinit_en` = 1. In that case, in the cycle after the write `sw_sync_o` is 0 and both `reinit_o` and `load_o` are 1. Otherwise `sw_sync_o` is 1 and no strobe is produced.
- R9: A write of 1 to the software-sync bit made during a loading point that completes a pending software request lets that load happen and leaves the bit at 1. A further load then follows at the next loading point.
- R10: A loading point with no pending request produces no load.
- R11: A rising edge on a trigger whose enable bit is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | NTRIG | Asynchronous hardware trigger inputs |
| trg_en_we | input | 1 | Write strobe for the trigger enable bits |
| trg_en_wdata | input | NTRIG | Write data for the trigger enable bits |
| sw_sync_we | input | 1 | Write strobe for the software-sync bit |
| sw_sync_wdata | input | 1 | Write data for the software-sync bit |
| hw_trig_hold | input | 1 | Hardware-trigger hold mode (enable bits are not cleared by events) |
| enh_sync | input | 1 | Enhanced synchronisation mode select |
| pwmsync_sel | input | 1 | Legacy mode: PWM-sync select |
| reinit_en | input | 1 | Legacy mode: counter reinitialise on software trigger |
| sw_cnt_rst | input | 1 | Enhanced mode: counter reset on software trigger |
| cnt_i | input | CW | Current timer counter value |
| ld_pt_en | input | 1 | Loading point qualifier |
| buf_mod_i | input | CW | Buffered modulus |
| buf_start_i | input | CW | Buffered counter start value |
| buf_chv_i | input | NCH*CW | Buffered channel values, channel 0 in the low bits |
| buf_mask_i | input | NCH | Buffered output mask |
| buf_inv_i | input | NCH/2 | Buffered pair inversion controls |
| buf_swoc_i | input | 2*NCH | Buffered software output control (enables in the low half, values in the high half) |
| act_mod_o | output | CW | Active modulus |
| act_start_o | output | CW | Active start value |
| act_chv_o | output | NCH*CW | Active channel values |
| act_mask_o | output | NCH | Active output mask |
| act_inv_o | output | NCH/2 | Active inversion controls |
| act_swoc_o | output | 2*NCH | Active software output control |
| load_o | output | 1 | One-cycle strobe: active set was just loaded |
| reinit_o | output | 1 | One-cycle strobe: counter must reload its start value |
| trg_en_o | output | NTRIG | Live trigger enable bits |
| sw_sync_o | output | 1 | Live software-sync bit |

## Verification
The hardest situation to reach is a bus write of 1 to a trigger's enable bit that lands in exactly the cycle in which that trigger's synchronised edge is detected. The bench reaches it by counting the two synchroniser edges after raising the trigger and issuing the write just before the third edge. A similar collision, a software write during the loading point that completes a pending request, is reached by raising the write strobe in the same cycle in which the counter is driven to the active modulus. All sixteen combinations of the four software-sync mode bits are swept, and in each one the immediate-or-deferred outcome is computed from the mode equation.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  typedef struct packed {
    logic enh;
    logic pwmsync_sel;
    logic reinit_en;
    logic sw_cnt_rst;
    logic hw_hold;
  } sync_mode_t;

  // Software trigger completes at once (no wait for a loading point)
  function automatic logic sw_is_immediate(input sync_mode_t m);
    if (m.enh) return m.sw_cnt_rst;
    return (!m.pwmsync_sel) && m.reinit_en;
  endfunction

  // Hold mode is honoured only in enhanced synchronisation
  function automatic logic hold_effective(input sync_mode_t m);
    return m.hw_hold && m.enh;
  endfunction

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_async,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= trig_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] && !prev;
endmodule

// File: rtl/trig_enable_ctrl.sv
module trig_enable_ctrl #(
  parameter int NTRIG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [NTRIG-1:0] wdata,
  input  logic [NTRIG-1:0] evt,
  input  logic             hold,
  output logic [NTRIG-1:0] en_o
);
  genvar i;
  generate
    for (i = 0; i < NTRIG; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)                 en_o[i] <= 1'b0;
        else if (we)             en_o[i] <= wdata[i];
        else if (evt[i] && !hold) en_o[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/sw_sync_ctrl.sv
module sw_sync_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic wdata,
  input  logic imm,
  input  logic lp,
  input  logic hw_evt_any,
  output logic sw_bit_o,
  output logic load_now_o,
  output logic reinit_now_o
);
  logic hw_pend;
  logic sw_trig;
  logic lp_sync;

  assign sw_trig      = we && wdata;
  assign reinit_now_o = sw_trig && imm;
  assign lp_sync      = lp && (hw_pend || sw_bit_o);
  assign load_now_o   = lp_sync || reinit_now_o;

  always_ff @(posedge clk) begin
    if (rst)          sw_bit_o <= 1'b0;
    else if (we)      sw_bit_o <= wdata && !imm;
    else if (lp_sync) sw_bit_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)             hw_pend <= 1'b0;
    else if (hw_evt_any) hw_pend <= 1'b1;
    else if (load_now_o) hw_pend <= 1'b0;
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [CW-1:0]       buf_mod_i,
  input  logic [CW-1:0]       buf_start_i,
  input  logic [NCH*CW-1:0]   buf_chv_i,
  input  logic [NCH-1:0]      buf_mask_i,
  input  logic [NCH/2-1:0]    buf_inv_i,
  input  logic [2*NCH-1:0]    buf_swoc_i,
  output logic [CW-1:0]       act_mod_o,
  output logic [CW-1:0]       act_start_o,
  output logic [NCH*CW-1:0]   act_chv_o,
  output logic [NCH-1:0]      act_mask_o,
  output logic [NCH/2-1:0]    act_inv_o,
  output logic [2*NCH-1:0]    act_swoc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_mod_o   <= '0;
      act_start_o <= '0;
      act_mask_o  <= '0;
      act_inv_o   <= '0;
      act_swoc_o  <= '0;
    end else if (load) begin
      act_mod_o   <= buf_mod_i;
      act_start_o <= buf_start_i;
      act_mask_o  <= buf_mask_i;
      act_inv_o   <= buf_inv_i;
      act_swoc_o  <= buf_swoc_i;
    end
  end

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst)       act_chv_o[c*CW +: CW] <= '0;
        else if (load) act_chv_o[c*CW +: CW] <= buf_chv_i[c*CW +: CW];
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_sync_ctrl.sv
module pwm_sync_ctrl #(
  parameter int CW          = 16,
  parameter int NCH         = 4,
  parameter int NTRIG       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NTRIG-1:0]    trig_i,
  input  logic                trg_en_we,
  input  logic [NTRIG-1:0]    trg_en_wdata,
  input  logic                sw_sync_we,
  input  logic                sw_sync_wdata,
  input  logic                hw_trig_hold,
  input  logic                enh_sync,
  input  logic                pwmsync_sel,
  input  logic                reinit_en,
  input  logic                sw_cnt_rst,
  input  logic [CW-1:0]       cnt_i,
  input  logic                ld_pt_en,
  input  logic [CW-1:0]       buf_mod_i,
  input  logic [CW-1:0]       buf_start_i,
  input  logic [NCH*CW-1:0]   buf_chv_i,
  input  logic [NCH-1:0]      buf_mask_i,
  input  logic [NCH/2-1:0]    buf_inv_i,
  input  logic [2*NCH-1:0]    buf_swoc_i,
  output logic [CW-1:0]       act_mod_o,
  output logic [CW-1:0]       act_start_o,
  output logic [NCH*CW-1:0]   act_chv_o,
  output logic [NCH-1:0]      act_mask_o,
  output logic [NCH/2-1:0]    act_inv_o,
  output logic [2*NCH-1:0]    act_swoc_o,
  output logic                load_o,
  output logic                reinit_o,
  output logic [NTRIG-1:0]    trg_en_o,
  output logic                sw_sync_o
);
  import pwm_sync_pkg::*;

  sync_mode_t       mode;
  logic [NTRIG-1:0] rise;
  logic [NTRIG-1:0] hw_evt;
  logic             lp;
  logic             load_now;
  logic             reinit_now;

  assign mode = '{enh: enh_sync, pwmsync_sel: pwmsync_sel, reinit_en: reinit_en,
                  sw_cnt_rst: sw_cnt_rst, hw_hold: hw_trig_hold};

  genvar k;
  generate
    for (k = 0; k < NTRIG; k++) begin : g_trig
      trig_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .trig_async (trig_i[k]),
        .rise_o     (rise[k])
      );
    end
  endgenerate

  assign hw_evt = rise & trg_en_o;
  assign lp     = ld_pt_en && (cnt_i == act_mod_o);

  trig_enable_ctrl #(.NTRIG(NTRIG)) u_en (
    .clk   (clk),
    .rst   (rst),
    .we    (trg_en_we),
    .wdata (trg_en_wdata),
    .evt   (hw_evt),
    .hold  (hold_effective(mode)),
    .en_o  (trg_en_o)
  );

  sw_sync_ctrl u_sw (
    .clk          (clk),
    .rst          (rst),
    .we           (sw_sync_we),
    .wdata        (sw_sync_wdata),
    .imm          (sw_is_immediate(mode)),
    .lp           (lp),
    .hw_evt_any   (|hw_evt),
    .sw_bit_o     (sw_sync_o),
    .load_now_o   (load_now),
    .reinit_now_o (reinit_now)
  );

  shadow_bank #(.CW(CW), .NCH(NCH)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .load        (load_now),
    .buf_mod_i   (buf_mod_i),
    .buf_start_i (buf_start_i),
    .buf_chv_i   (buf_chv_i),
    .buf_mask_i  (buf_mask_i),
    .buf_inv_i   (buf_inv_i),
    .buf_swoc_i  (buf_swoc_i),
    .act_mod_o   (act_mod_o),
    .act_start_o (act_start_o),
    .act_chv_o   (act_chv_o),
    .act_mask_o  (act_mask_o),
    .act_inv_o   (act_inv_o),
    .act_swoc_o  (act_swoc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      load_o   <= 1'b0;
      reinit_o <= 1'b0;
    end else begin
      load_o   <= load_now;
      reinit_o <= reinit_now;
    end
  end
endmodule

// File: rtl/pwm_sync_ctrl_chk.sv
module pwm_sync_ctrl_chk #(
  parameter int CW    = 16,
  parameter int NTRIG = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             trg_en_we,
  input logic             sw_sync_we,
  input logic             sw_sync_wdata,
  input logic             hw_trig_hold,
  input logic             enh_sync,
  input logic             pwmsync_sel,
  input logic             reinit_en,
  input logic             sw_cnt_rst,
  input logic [CW-1:0]    cnt_i,
  input logic             ld_pt_en,
  input logic [CW-1:0]    act_mod_o,
  input logic [CW-1:0]    act_start_o,
  input logic             load_o,
  input logic             reinit_o,
  input logic [NTRIG-1:0] trg_en_o,
  input logic             sw_sync_o
);
  logic imm_cfg;
  logic at_lp;
  assign imm_cfg = enh_sync ? sw_cnt_rst : (!pwmsync_sel && reinit_en);
  assign at_lp   = ld_pt_en && (cnt_i == act_mod_o);

  a_r1_active_held: assert property (@(posedge clk) disable iff (rst)
    !load_o |-> ($stable(act_mod_o) && $stable(act_start_o)));

  a_r8_immediate: assert property (@(posedge clk) disable iff (rst)
    (sw_sync_we && sw_sync_wdata && imm_cfg) |=> (reinit_o && load_o && !sw_sync_o));

  a_r8_reinit_with_load: assert property (@(posedge clk) disable iff (rst)
    reinit_o |-> load_o);

  a_r6_deferred_set: assert property (@(posedge clk) disable iff (rst)
    (sw_sync_we && sw_sync_wdata && !imm_cfg) |=> sw_sync_o);

  a_r6_write_zero: assert property (@(posedge clk) disable iff (rst)
    (sw_sync_we && !sw_sync_wdata) |=> !sw_sync_o);

  a_r7_lp_completes: assert property (@(posedge clk) disable iff (rst)
    (at_lp && sw_sync_o && !sw_sync_we) |=> (load_o && !sw_sync_o));

  a_r5_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (hw_trig_hold && enh_sync && !trg_en_we) |=> ((~trg_en_o & $past(trg_en_o)) == '0));

  a_r2_no_self_set: assert property (@(posedge clk) disable iff (rst)
    !trg_en_we |=> ((trg_en_o & ~$past(trg_en_o)) == '0));
endmodule

bind pwm_sync_ctrl pwm_sync_ctrl_chk #(.CW(CW), .NTRIG(NTRIG)) u_chk (.*);

// File: tb/pwm_sync_ctrl_tb.sv
module pwm_sync_ctrl_tb;
  localparam int CW = 16;
  localparam int NCH = 4;
  localparam int NTRIG = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NTRIG-1:0] trig_i = '0;
  logic trg_en_we = 1'b0;
  logic [NTRIG-1:0] trg_en_wdata = '0;
  logic sw_sync_we = 1'b0, sw_sync_wdata = 1'b0;
  logic hw_trig_hold = 1'b0, enh_sync = 1'b0, pwmsync_sel = 1'b1, reinit_en = 1'b0, sw_cnt_rst = 1'b0;
  logic [CW-1:0] cnt_i = '1;
  logic ld_pt_en = 1'b0;
  logic [CW-1:0] buf_mod_i = '0, buf_start_i = '0;
  logic [NCH*CW-1:0] buf_chv_i = '0;
  logic [NCH-1:0] buf_mask_i = '0;
  logic [NCH/2-1:0] buf_inv_i = '0;
  logic [2*NCH-1:0] buf_swoc_i = '0;
  logic [CW-1:0] act_mod_o, act_start_o;
  logic [NCH*CW-1:0] act_chv_o;
  logic [NCH-1:0] act_mask_o;
  logic [NCH/2-1:0] act_inv_o;
  logic [2*NCH-1:0] act_swoc_o;
  logic load_o, reinit_o, sw_sync_o;
  logic [NTRIG-1:0] trg_en_o;

  int n_chk = 0, n_fail = 0;
  logic [CW-1:0] exp_mod = '0;
  logic [CW-1:0] exp_start = '0;
  logic [NCH*CW-1:0] exp_chv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_sync_ctrl #(.CW(CW), .NCH(NCH), .NTRIG(NTRIG)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_buf(input int seed);
    buf_mod_i   = CW'(16'h0040 + seed);
    buf_start_i = CW'(seed * 3);
    buf_chv_i   = {CW'(seed + 4), CW'(seed + 3), CW'(seed + 2), CW'(seed + 1)};
    buf_mask_i  = NCH'(seed);
    buf_inv_i   = (NCH/2)'(seed);
    buf_swoc_i  = (2*NCH)'(seed * 5);
  endtask

  task automatic take_buf();
    exp_mod = buf_mod_i; exp_start = buf_start_i; exp_chv = buf_chv_i;
  endtask

  task automatic check_act(input string req);
    chk(req, 64'(act_mod_o), 64'(exp_mod));
    chk(req, 64'(act_start_o), 64'(exp_start));
    chk(req, act_chv_o, exp_chv);
  endtask

  task automatic do_lp();
    cnt_i = exp_mod; ld_pt_en = 1'b1;
    tick();
    ld_pt_en = 1'b0; cnt_i = '1;
  endtask

  task automatic trg_write(input logic [NTRIG-1:0] v);
    trg_en_we = 1'b1; trg_en_wdata = v;
    tick();
    trg_en_we = 1'b0;
  endtask

  task automatic sw_write(input logic v);
    sw_sync_we = 1'b1; sw_sync_wdata = v;
    tick();
    sw_sync_we = 1'b0;
  endtask

  task automatic pulse_trig(input int idx);
    trig_i[idx] = 1'b1;
    tick(); tick(); tick();
    trig_i[idx] = 1'b0;
    tick(); tick(); tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 reset load", 64'(load_o), 0);
    chk("R8 reset reinit", 64'(reinit_o), 0);
    chk("R3 reset enables", 64'(trg_en_o), 0);
    chk("R6 reset sw bit", 64'(sw_sync_o), 0);
    check_act("R1 reset active");

    // R8 / R6 / R7: sweep all software-sync mode combinations
    for (int m = 0; m < 16; m++) begin
      logic exp_imm;
      enh_sync = m[3]; pwmsync_sel = m[2]; reinit_en = m[1]; sw_cnt_rst = m[0];
      exp_imm = enh_sync ? sw_cnt_rst : (!pwmsync_sel && reinit_en);
      set_buf(m + 1);
      sw_write(1'b1);
      chk("R8 sw bit after trigger", 64'(sw_sync_o), 64'(!exp_imm));
      chk("R8 reinit strobe", 64'(reinit_o), 64'(exp_imm));
      chk("R8 load strobe", 64'(load_o), 64'(exp_imm));
      if (exp_imm) begin
        take_buf();
        check_act("R8 immediate copy");
      end else begin
        check_act("R1 no copy while pending");
        set_buf(m + 40);
        do_lp();
        take_buf();
        chk("R7 load at loading point", 64'(load_o), 1);
        chk("R7 sw bit cleared", 64'(sw_sync_o), 0);
        chk("R7 no reinit", 64'(reinit_o), 0);
        check_act("R7 copy at loading point");
      end
      tick();
      chk("R1 strobe one cycle", 64'(load_o), 0);
    end

    // Hardware triggers in legacy mode
    enh_sync = 1'b0; pwmsync_sel = 1'b1; reinit_en = 1'b0; sw_cnt_rst = 1'b0; hw_trig_hold = 1'b0;
    trg_write(3'b111);
    chk("R3 enables written", 64'(trg_en_o), 64'h7);
    pulse_trig(1);
    chk("R3 only fired bit clears", 64'(trg_en_o), 64'h5);
    chk("R2 no load before loading point", 64'(load_o), 0);
    set_buf(20);
    check_act("R1 buffer change alone");
    do_lp();
    take_buf();
    chk("R2 trigger loads at loading point", 64'(load_o), 1);
    chk("R7 enables unchanged by load", 64'(trg_en_o), 64'h5);
    check_act("R2 copy");
    tick();

    // R11 / R10: disabled trigger ignored
    trg_write(3'b000);
    pulse_trig(2);
    chk("R11 disabled stays 0", 64'(trg_en_o), 0);
    set_buf(21);
    do_lp();
    chk("R10 no pending no load", 64'(load_o), 0);
    check_act("R11 active unchanged");

    // R4: write 1 colliding with event
    trg_write(3'b001);
    trig_i[0] = 1'b1;
    tick(); tick();
    trg_en_we = 1'b1; trg_en_wdata = 3'b001;
    tick();
    trg_en_we = 1'b0;
    chk("R4 bit stays set", 64'(trg_en_o), 64'h1);
    trig_i[0] = 1'b0;
    tick(); tick(); tick();
    set_buf(22);
    do_lp();
    take_buf();
    chk("R4 sync still requested", 64'(load_o), 1);
    check_act("R4 copy");
    tick();

    // R5: hold mode
    enh_sync = 1'b1; hw_trig_hold = 1'b1;
    trg_write(3'b111);
    pulse_trig(0);
    chk("R5 hold keeps enables", 64'(trg_en_o), 64'h7);
    set_buf(23);
    do_lp();
    take_buf();
    chk("R5 hold still syncs", 64'(load_o), 1);
    tick();
    enh_sync = 1'b0;
    pulse_trig(1);
    chk("R5 hold ignored in legacy", 64'(trg_en_o), 64'h5);
    do_lp();
    take_buf();
    chk("R5 legacy event loads", 64'(load_o), 1);
    hw_trig_hold = 1'b0;
    tick();

    // R9: rewrite during completing loading point
    sw_write(1'b1);
    chk("R9 bit set", 64'(sw_sync_o), 1);
    set_buf(24);
    cnt_i = exp_mod; ld_pt_en = 1'b1; sw_sync_we = 1'b1; sw_sync_wdata = 1'b1;
    tick();
    ld_pt_en = 1'b0; cnt_i = '1; sw_sync_we = 1'b0;
    take_buf();
    chk("R9 load happens", 64'(load_o), 1);
    chk("R9 bit stays 1", 64'(sw_sync_o), 1);
    set_buf(25);
    do_lp();
    take_buf();
    chk("R9 second load", 64'(load_o), 1);
    chk("R9 bit clears", 64'(sw_sync_o), 0);
    check_act("R9 copy");
    tick();

    // R6: write 0 withdraws request
    sw_write(1'b1);
    sw_write(1'b0);
    chk("R6 write 0 clears", 64'(sw_sync_o), 0);
    set_buf(26);
    do_lp();
    chk("R6 withdrawn no load", 64'(load_o), 0);
    check_act("R6 active unchanged");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule